// File: doc/BRIEF.md
# Luminance Peaking Filter With Coring

This block sharpens an 8-bit luminance stream. It slides a seven-sample window along the accepted samples. From that window it builds three detail signals, each a symmetric second difference around the centre sample:

- a high-pass term that peaks at half the sample rate;
- a band-pass term centred at a quarter of the sample rate;
- a lower band-pass term that uses the outermost taps and is centred near one sixth of the sample rate.

Each term carries its own 3-bit weight. The weighted sum is reduced to an 11-bit signed detail value, and that value is shaped in turn:

- coring removes small amplitudes;
- a knee-based attenuation tames large amplitudes;
- a separate control shrinks negative detail, so undershoots can be made smaller than overshoots.

The shaped detail is added to the centre sample and the result is clipped to the 8-bit range.

Input samples are qualified by a valid strobe, and the window advances only on valid samples. Each accepted sample produces one output sample two clock cycles later. That output belongs to the centre of the window, which is the sample accepted three valid samples before the one that completed it. The weight and shaping controls are plain static inputs. They are read in the cycle the filtered result is registered.

Top module: `peak_filter`

## Requirements
- R1: While `rst` is high (synchronous), the next clock edge drives `out_valid` to 0 and `out_luma` to 0; the sample window is cleared to zero.
- R2: Every clock cycle with `in_valid` high yields exactly one cycle with `out_valid` high, exactly two clock cycles later; no other cycle raises `out_valid`.
- R3: The window shifts only on cycles with `in_valid` high. The output triggered by the n-th accepted sample is centred on accepted sample n-3, and idle cycles between samples do not change the result.
- R4: With centre c and neighbours at distance d, a band's raw value is 2c - x(c-d) - x(c+d), using d = 1 (high-pass), 2 (quarter-rate) and 3 (low band). The detail sum S is the total of weight times raw. The 11-bit detail has sign(S) and magnitude floor(|S|/16).
- R5: Weight code k (3 bits) selects a numerator of k sixteenths for k = 0..6, and code 7 selects 8 sixteenths.
- R6: Coring code q (4 bits) sets a level of 8*q. A detail magnitude at or below the level becomes 0; above it, the level is subtracted.
- R7: Amplitude attenuation code a (2 bits) selects f = 0, 1, 2, 4 for a = 0..3. The cored magnitude m loses floor((m - 64) * f / 4) when m > 64 and is unchanged otherwise.
- R8: Undershoot code u (2 bits) selects g = 0, 1, 2, 4 for u = 0..3. For negative detail the magnitude m becomes m - floor(m * g / 4); positive detail is unchanged.
- R9: The final magnitude is divided by 4 (truncated), added to or subtracted from the centre sample according to the detail sign, and the result is clipped to 0..255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_luma` |
| in_luma | input | 8 | Input luminance sample |
| wgt_hi | input | 3 | Weight code for the half-rate high-pass term |
| wgt_mid | input | 3 | Weight code for the quarter-rate band-pass term |
| wgt_lo | input | 3 | Weight code for the low band-pass term |
| core_lvl | input | 4 | Coring code, level = 8 x code |
| amp_att | input | 2 | Amplitude-dependent attenuation code |
| under_att | input | 2 | Undershoot attenuation code |
| out_valid | output | 1 | Qualifies `out_luma` |
| out_luma | output | 8 | Peaked, clipped luminance |

## Verification
Coring and undershoot attenuation both act on one negative detail value in the same cycle. The order matters, because attenuating before coring would give a different magnitude. A vector with a dark centre between bright neighbours, a nonzero coring code and a nonzero undershoot code provokes this case. Its output is compared with the value obtained by first subtracting the coring level and then removing the undershoot fraction. A second vector pairs the largest amplitude attenuation with a detail above the knee, and others drive the sum past either rail so that clipping falls in the same cycle as full weighting.

// File: rtl/peak_pkg.sv
package peak_pkg;

    // 3-bit weight code to numerator over 16: 0..6 direct, 7 means 8
    function automatic logic [3:0] weight_num(input logic [2:0] code);
        return (code == 3'd7) ? 4'd8 : {1'b0, code};
    endfunction

    // 2-bit attenuation code to numerator over 4: 0,1,2 direct, 3 means 4
    function automatic logic [2:0] atten_num(input logic [1:0] code);
        return (code == 2'd3) ? 3'd4 : {1'b0, code};
    endfunction

endpackage

// File: rtl/peak_band.sv
module peak_band
    import peak_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int SUM_W = 16
) (
    input  logic [PIX_W-1:0]        centre,
    input  logic [PIX_W-1:0]        near_new,
    input  logic [PIX_W-1:0]        near_old,
    input  logic [2:0]              wcode,
    output logic signed [SUM_W-1:0] weighted
);
    localparam int EXT = SUM_W - PIX_W;

    logic signed [SUM_W-1:0] c_s, n_s, o_s, raw_s, w_s;

    always_comb begin
        c_s      = $signed({{EXT{1'b0}}, centre});
        n_s      = $signed({{EXT{1'b0}}, near_new});
        o_s      = $signed({{EXT{1'b0}}, near_old});
        raw_s    = (c_s <<< 1) - n_s - o_s;
        w_s      = $signed({{(SUM_W-4){1'b0}}, weight_num(wcode)});
        weighted = raw_s * w_s;
    end
endmodule

// File: rtl/peak_shaper.sv
module peak_shaper
    import peak_pkg::*;
#(
    parameter int SUM_W  = 16,
    parameter int MAG_W  = 10,
    parameter int SHIFT  = 4,
    parameter int CORE_W = 4,
    parameter int KNEE   = 64
) (
    input  logic signed [SUM_W-1:0] sum,
    input  logic [CORE_W-1:0]       core_code,
    input  logic [1:0]              amp_code,
    input  logic [1:0]              under_code,
    output logic                    neg,
    output logic [MAG_W-1:0]        mag_det,
    output logic [MAG_W-1:0]        mag_core,
    output logic [MAG_W-1:0]        mag_amp,
    output logic [MAG_W-1:0]        mag_fin
);
    localparam int PW = MAG_W + 3;

    logic [SUM_W-1:0] abs_v;
    logic [MAG_W-1:0] level;
    logic [MAG_W-1:0] excess;
    logic [PW-1:0]    amp_prod;
    logic [PW-1:0]    und_prod;

    always_comb begin
        neg     = sum[SUM_W-1];
        abs_v   = neg ? $unsigned(-sum) : $unsigned(sum);
        mag_det = MAG_W'(abs_v >> SHIFT);

        // coring: shrink magnitude by the level, floor at zero
        level    = MAG_W'({core_code, 3'b000});
        mag_core = (mag_det > level) ? (mag_det - level) : '0;

        // amplitude attenuation above the knee
        excess   = (mag_core > MAG_W'(KNEE)) ? (mag_core - MAG_W'(KNEE)) : '0;
        amp_prod = {3'b000, excess} * {{MAG_W{1'b0}}, atten_num(amp_code)};
        mag_amp  = mag_core - MAG_W'(amp_prod >> 2);

        // undershoot attenuation, negative detail only
        und_prod = {3'b000, mag_amp} * {{MAG_W{1'b0}}, atten_num(under_code)};
        mag_fin  = neg ? (mag_amp - MAG_W'(und_prod >> 2)) : mag_amp;
    end
endmodule

// File: rtl/peak_filter.sv
module peak_filter #(
    parameter int PIX_W    = 8,
    parameter int DET_W    = 11,
    parameter int LOW_SPAN = 3,
    parameter int CORE_W   = 4,
    parameter int KNEE     = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_luma,
    input  logic [2:0]        wgt_hi,
    input  logic [2:0]        wgt_mid,
    input  logic [2:0]        wgt_lo,
    input  logic [CORE_W-1:0] core_lvl,
    input  logic [1:0]        amp_att,
    input  logic [1:0]        under_att,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_luma
);
    localparam int TAPS   = 2 * LOW_SPAN + 1;
    localparam int CTR    = LOW_SPAN;
    localparam int BANDS  = 3;
    localparam int SUM_W  = PIX_W + 8;
    localparam int MAG_W  = DET_W - 1;
    localparam int RES_W  = MAG_W + 2;
    localparam int SHIFT  = 4;

    function automatic int band_dist(input int k);
        return (k == 0) ? 1 : ((k == 1) ? 2 : LOW_SPAN);
    endfunction

    typedef struct packed {
        logic [TAPS-1:0][PIX_W-1:0] win;   // index 0 = newest
        logic                       v1;
        logic                       ov;
        logic [PIX_W-1:0]           oy;
    } state_t;

    state_t st_d, st_q;

    logic [2:0]              wsel    [BANDS];
    logic signed [SUM_W-1:0] band_w  [BANDS];
    logic signed [SUM_W-1:0] det_sum;
    logic                    det_neg;
    logic [MAG_W-1:0]        mag_det, mag_core, mag_amp, mag_fin;
    logic [MAG_W-1:0]        add_mag;
    logic signed [RES_W-1:0] res;

    assign wsel[0] = wgt_hi;
    assign wsel[1] = wgt_mid;
    assign wsel[2] = wgt_lo;

    for (genvar b = 0; b < BANDS; b++) begin : g_band
        peak_band #(
            .PIX_W(PIX_W),
            .SUM_W(SUM_W)
        ) u_band (
            .centre  (st_q.win[CTR]),
            .near_new(st_q.win[CTR - band_dist(b)]),
            .near_old(st_q.win[CTR + band_dist(b)]),
            .wcode   (wsel[b]),
            .weighted(band_w[b])
        );
    end

    always_comb begin
        det_sum = '0;
        for (int b = 0; b < BANDS; b++) begin
            det_sum = det_sum + band_w[b];
        end
    end

    peak_shaper #(
        .SUM_W (SUM_W),
        .MAG_W (MAG_W),
        .SHIFT (SHIFT),
        .CORE_W(CORE_W),
        .KNEE  (KNEE)
    ) u_shape (
        .sum       (det_sum),
        .core_code (core_lvl),
        .amp_code  (amp_att),
        .under_code(under_att),
        .neg       (det_neg),
        .mag_det   (mag_det),
        .mag_core  (mag_core),
        .mag_amp   (mag_amp),
        .mag_fin   (mag_fin)
    );

    always_comb begin
        st_d    = st_q;
        add_mag = mag_fin >> 2;
        res     = $signed({{(RES_W-PIX_W){1'b0}}, st_q.win[CTR]});
        if (det_neg) begin
            res = res - $signed({2'b00, add_mag});
        end else begin
            res = res + $signed({2'b00, add_mag});
        end

        if (in_valid) begin
            st_d.win = {st_q.win[TAPS-2:0], in_luma};
        end
        st_d.v1 = in_valid;
        st_d.ov = st_q.v1;
        if (st_q.v1) begin
            if (res < 0) begin
                st_d.oy = '0;
            end else if (res > $signed(RES_W'((1 << PIX_W) - 1))) begin
                st_d.oy = '1;
            end else begin
                st_d.oy = PIX_W'(res);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_luma  = st_q.oy;
endmodule

// File: rtl/peak_checker.sv
module peak_checker #(
    parameter int PIX_W = 8,
    parameter int MAG_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_luma,
    input logic             det_neg,
    input logic [MAG_W-1:0] mag_det,
    input logic [MAG_W-1:0] mag_core,
    input logic [MAG_W-1:0] mag_amp,
    input logic [MAG_W-1:0] mag_fin
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_luma == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R6
    coring_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
        mag_core <= mag_det);

    // R7
    amp_limit_chk: assert property (@(posedge clk) disable iff (rst)
        mag_amp <= mag_core);

    // R8
    overshoot_kept_chk: assert property (@(posedge clk) disable iff (rst)
        !det_neg |-> (mag_fin == mag_amp));

    // R8
    undershoot_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
        det_neg |-> (mag_fin <= mag_amp));
endmodule

bind peak_filter peak_checker #(
    .PIX_W(PIX_W),
    .MAG_W(MAG_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_luma (out_luma),
    .det_neg  (det_neg),
    .mag_det  (mag_det),
    .mag_core (mag_core),
    .mag_amp  (mag_amp),
    .mag_fin  (mag_fin)
);

// File: tb/peak_filter_test.sv
module peak_filter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_luma = '0;
    logic [2:0] wgt_hi = '0, wgt_mid = '0, wgt_lo = '0;
    logic [3:0] core_lvl = '0;
    logic [1:0] amp_att = '0, under_att = '0;
    logic       out_valid;
    logic [7:0] out_luma;

    int checks = 0;
    int errors = 0;
    int in_cnt = 0;
    int out_cnt = 0;
    bit done = 0;
    logic [7:0] got [0:511];

    always #10 clk = ~clk;

    peak_filter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_luma(in_luma),
        .wgt_hi(wgt_hi), .wgt_mid(wgt_mid), .wgt_lo(wgt_lo),
        .core_lvl(core_lvl), .amp_att(amp_att), .under_att(under_att),
        .out_valid(out_valid), .out_luma(out_luma)
    );

    typedef struct packed {
        logic [2:0] wh, wm, wl;
        logic [3:0] core;
        logic [1:0] amp, und;
        logic [7:0] c, s, exp;
    } vec_t;

    // centre c surrounded by flat level s; raw = 2(c-s) in each band
    localparam vec_t TBL [13] = '{
        '{3'd4, 3'd4, 3'd4, 4'd0,  2'd0, 2'd0, 8'd100, 8'd0,   8'd137}, // R4 R9
        '{3'd4, 3'd4, 3'd4, 4'd15, 2'd0, 2'd0, 8'd100, 8'd0,   8'd107}, // R6 max level
        '{3'd4, 3'd4, 3'd4, 4'd0,  2'd3, 2'd0, 8'd100, 8'd0,   8'd116}, // R7 full
        '{3'd4, 3'd4, 3'd4, 4'd0,  2'd1, 2'd0, 8'd100, 8'd0,   8'd132}, // R7 quarter
        '{3'd4, 3'd4, 3'd4, 4'd0,  2'd3, 2'd0, 8'd100, 8'd80,  8'd107}, // R7 below knee
        '{3'd4, 3'd4, 3'd4, 4'd0,  2'd0, 2'd2, 8'd50,  8'd150, 8'd32},  // R8 half
        '{3'd4, 3'd4, 3'd4, 4'd0,  2'd0, 2'd3, 8'd50,  8'd150, 8'd50},  // R8 full
        '{3'd7, 3'd7, 3'd7, 4'd0,  2'd0, 2'd0, 8'd250, 8'd50,  8'd255}, // R9 high clip, R5 code 7
        '{3'd7, 3'd7, 3'd7, 4'd0,  2'd0, 2'd0, 8'd10,  8'd200, 8'd0},   // R9 low clip
        '{3'd0, 3'd0, 3'd0, 4'd0,  2'd0, 2'd0, 8'd77,  8'd3,   8'd77},  // R5 code 0
        '{3'd6, 3'd0, 3'd0, 4'd0,  2'd0, 2'd0, 8'd120, 8'd100, 8'd123}, // R5 code 6
        '{3'd4, 3'd4, 3'd4, 4'd5,  2'd0, 2'd1, 8'd60,  8'd140, 8'd45},  // R6 + R8 same cycle
        '{3'd4, 3'd4, 3'd4, 4'd3,  2'd0, 2'd0, 8'd100, 8'd84,  8'd100}  // R6 equal level
    };

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (out_cnt < 512) got[out_cnt] = out_luma;
            out_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] v);
        @(negedge clk);
        in_valid = 1'b1;
        in_luma  = v;
        in_cnt++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic set_cfg(input vec_t v);
        wgt_hi = v.wh; wgt_mid = v.wm; wgt_lo = v.wl;
        core_lvl = v.core; amp_att = v.amp; under_att = v.und;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", int'(out_valid), 0);
        check("R1 luma", int'(out_luma), 0);
        rst = 1'b0;
        idle(2);
        check("R2 idle no valid", int'(out_valid), 0);

        // R2: single sample, output exactly two cycles later
        push(8'd0);
        @(negedge clk); in_valid = 1'b0;
        check("R2 after one cycle", int'(out_valid), 0);
        @(negedge clk);
        check("R2 after two cycles", int'(out_valid), 1);
        @(negedge clk);
        check("R2 single pulse", int'(out_valid), 0);
        idle(2);

        // main vector table
        for (int k = 0; k < 13; k++) begin
            set_cfg(TBL[k]);
            base = in_cnt;
            for (int j = 0; j < 7; j++) push((j == 3) ? TBL[k].c : TBL[k].s);
            idle(4);
            check($sformatf("R4-vector%0d", k), int'(got[base + 6]), int'(TBL[k].exp));
        end

        // R3: idle gap inside the window leaves the result unchanged
        set_cfg(TBL[0]);
        base = in_cnt;
        push(8'd0); push(8'd0); push(8'd0); push(8'd100);
        idle(3);
        push(8'd0); idle(2);
        push(8'd0); push(8'd0);
        idle(4);
        check("R3 gap", int'(got[base + 6]), 137);

        // R2: one output per accepted sample overall
        check("R2 count", out_cnt, in_cnt);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule